// File: doc/BRIEF.md
# Dual-Rate LED Blink and Dim Generator

This block turns a slow timebase enable into two independent blink waveforms and uses them to steer sixteen open-drain LED pins. Each waveform has its own period and on-fraction. The period comes from an 8-bit prescale value, which divides the timebase ahead of a 256-step phase counter. The on-fraction comes from an 8-bit duty value: the waveform is "on" while the phase count is below it.

Each LED has a 2-bit mode field in a 32-bit mode word. The mode makes the LED's pull-low enable stay released, stay asserted, or follow one of the two waveforms. The host applies new prescale and duty values at any time, but each rate generator only takes them when its phase counter wraps, so a period is never cut short or stretched. The sampled pin levels come back through a two-flop synchronizer as two 8-bit status words, so unused pins can serve as general-purpose inputs.

The timebase enable is a single-cycle pulse derived from the system clock. At a 40.96 kHz rate, a prescale value of 0 gives a 6.25 ms period and a value of 255 gives 1.6 s.

Top module: `led_blink_gen`

## Requirements
- R1: While reset is asserted, and on leaving reset, every pull-low enable is 0, both status words are 0, both rate generators start at phase 0 with prescale 0 and duty 0x80.
- R2: Mode code 00 releases the LED (pull_low bit 0) and code 01 asserts it (pull_low bit 1), one clock after the mode is presented.
- R3: Mode code 10 makes the LED's pull_low bit equal the "on" level of rate 0, and code 11 that of rate 1, with one clock of latency.
- R4: A rate generator's phase advances by one, wrapping from 255 to 0, on every (prescale+1)-th timebase tick, so one period is 256*(prescale+1) ticks.
- R5: A rate's "on" level is high exactly while its phase is below its duty value, so a full period holds duty on-steps; duty 0 keeps it off, and the reset duty 0x80 gives half on.
- R6: New prescale or duty inputs are taken by a rate generator only in the step where its phase wraps from 255 to 0; in any other cycle the values in use stay unchanged.
- R7: LED k is controlled by mode_sel bits [2k+1:2k], so LED0 uses bits 1:0 and LED15 bits 31:30.
- R8: stat_lo bit k equals pin_in bit k and stat_hi bit k equals pin_in bit k+8, two clocks after the pin level is sampled.
- R9: Without a timebase tick, neither the prescale count nor the phase of either rate changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Timebase enable, one clock wide |
| pre0_in | input | 8 | Prescale value for rate 0 |
| duty0_in | input | 8 | Duty value for rate 0 |
| pre1_in | input | 8 | Prescale value for rate 1 |
| duty1_in | input | 8 | Duty value for rate 1 |
| mode_sel | input | 32 | Two mode bits per LED, LED k in bits [2k+1:2k] |
| pin_in | input | 16 | Sampled pad levels of the LED pins |
| pull_low | output | 16 | Open-drain enables, 1 pulls the pin low |
| stat_lo | output | 8 | Synchronized levels of pins 7..0 |
| stat_hi | output | 8 | Synchronized levels of pins 15..8 |

## Verification
A prescale count or phase that goes wrong inside a rate generator shows up on every LED in a following mode. It appears as an on-window shifted or of the wrong length, within one phase step of the fault, and it stays wrong until the period boundary. A duty or prescale value latched at the wrong moment changes the on-count of the current period. That is why the bench counts on-cycles over whole periods, in addition to the cycle-by-cycle comparison against its reference model. A mapping or synchronizer fault is visible on the very next clock, or two clocks later for the status words.

// File: rtl/led_blink_gen.sv
module led_blink_gen #(
  parameter int PW = 8,
  parameter int NCH = 16,
  parameter logic [PW-1:0] DUTY_RST = 8'h80
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [PW-1:0]    pre0_in,
  input  logic [PW-1:0]    duty0_in,
  input  logic [PW-1:0]    pre1_in,
  input  logic [PW-1:0]    duty1_in,
  input  logic [2*NCH-1:0] mode_sel,
  input  logic [NCH-1:0]   pin_in,
  output logic [NCH-1:0]   pull_low,
  output logic [NCH/2-1:0] stat_lo,
  output logic [NCH/2-1:0] stat_hi
);
  localparam int HALF = NCH / 2;

  logic [1:0][PW-1:0] pre_in_v, duty_in_v;
  logic [1:0][PW-1:0] pre_cnt, phase, pre_s, duty_s;
  logic [1:0]         step, dim_on;
  logic [NCH-1:0]     sync1, sync2;

  assign pre_in_v  = {pre1_in, pre0_in};
  assign duty_in_v = {duty1_in, duty0_in};

  for (genvar r = 0; r < 2; r++) begin : g_rate
    assign step[r]   = tick && (pre_cnt[r] == pre_s[r]);
    assign dim_on[r] = phase[r] < duty_s[r];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < 2; r++) begin
        pre_cnt[r] <= '0;
        phase[r]   <= '0;
        pre_s[r]   <= '0;
        duty_s[r]  <= DUTY_RST;
      end
    end else if (tick) begin
      for (int r = 0; r < 2; r++) begin
        if (step[r]) begin
          pre_cnt[r] <= '0;
          phase[r]   <= phase[r] + 1'b1;
          if (&phase[r]) begin
            pre_s[r]  <= pre_in_v[r];
            duty_s[r] <= duty_in_v[r];
          end
        end else begin
          pre_cnt[r] <= pre_cnt[r] + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pull_low <= '0;
    end else begin
      for (int k = 0; k < NCH; k++) begin
        case (mode_sel[2*k +: 2])
          2'b00:   pull_low[k] <= 1'b0;
          2'b01:   pull_low[k] <= 1'b1;
          2'b10:   pull_low[k] <= dim_on[0];
          default: pull_low[k] <= dim_on[1];
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
    end else begin
      sync1 <= pin_in;
      sync2 <= sync1;
    end
  end

  assign stat_lo = sync2[HALF-1:0];
  assign stat_hi = sync2[NCH-1:HALF];
endmodule

// File: rtl/led_blink_chk.sv
module led_blink_chk #(
  parameter int PW = 8,
  parameter int NCH = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic                tick,
  input logic [2*NCH-1:0]    mode_sel,
  input logic [NCH-1:0]      pull_low,
  input logic [1:0][PW-1:0]  phase,
  input logic [1:0][PW-1:0]  pre_cnt,
  input logic [1:0][PW-1:0]  pre_s,
  input logic [1:0][PW-1:0]  duty_s
);
  for (genvar k = 0; k < NCH; k++) begin : g_ch
    a_r2_mode_off: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_sel[2*k +: 2] == 2'b00) |=> !pull_low[k]);
    a_r2_mode_on: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_sel[2*k +: 2] == 2'b01) |=> pull_low[k]);
    a_r5_zero_duty_off0: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_sel[2*k +: 2] == 2'b10 && duty_s[0] == '0) |=> !pull_low[k]);
    a_r5_zero_duty_off1: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_sel[2*k +: 2] == 2'b11 && duty_s[1] == '0) |=> !pull_low[k]);
  end

  for (genvar r = 0; r < 2; r++) begin : g_rt
    a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> ($stable(phase[r]) && $stable(pre_cnt[r])));
    a_r4_wait_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && pre_cnt[r] != pre_s[r]) |=> $stable(phase[r]));
    a_r4_step_inc: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && pre_cnt[r] == pre_s[r]) |=> (phase[r] == PW'($past(phase[r]) + 1'b1)));
    a_r6_latch_only_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      !(tick && pre_cnt[r] == pre_s[r] && (&phase[r])) |=> ($stable(pre_s[r]) && $stable(duty_s[r])));
  end
endmodule

bind led_blink_gen led_blink_chk #(.PW(PW), .NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .mode_sel(mode_sel),
  .pull_low(pull_low), .phase(phase), .pre_cnt(pre_cnt),
  .pre_s(pre_s), .duty_s(duty_s)
);

// File: tb/tb_led_blink_gen.sv
module tb_led_blink_gen;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        tick = 0;
  logic [7:0]  pre0_in = 0, duty0_in = 8'h80, pre1_in = 0, duty1_in = 8'h80;
  logic [31:0] mode_sel = 0;
  logic [15:0] pin_in = 0;
  logic [15:0] pull_low;
  logic [7:0]  stat_lo, stat_hi;

  int checks = 0, fails = 0, cyc = 0;
  int tick_mode = 0;
  bit rnd_pins = 0;
  string cur_tag = "R1";

  int ph[2], pc[2], ps[2], du[2];
  logic [15:0] e_pull, s1, s2;

  led_blink_gen dut (.*);

  always #2 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    #1;
    case (tick_mode)
      0: tick = 1'b1;
      1: tick = cyc[0];
      default: tick = 1'b0;
    endcase
    if (rnd_pins) pin_in = 16'($urandom);
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int r = 0; r < 2; r++) begin ph[r] = 0; pc[r] = 0; ps[r] = 0; du[r] = 128; end
      e_pull = 0; s1 = 0; s2 = 0;
    end else begin
      for (int k = 0; k < 16; k++) begin
        case (mode_sel[2*k +: 2])
          2'b00: e_pull[k] = 1'b0;
          2'b01: e_pull[k] = 1'b1;
          2'b10: e_pull[k] = (ph[0] < du[0]);
          default: e_pull[k] = (ph[1] < du[1]);
        endcase
      end
      s2 = s1; s1 = pin_in;
      if (tick) begin
        for (int r = 0; r < 2; r++) begin
          if (pc[r] == ps[r]) begin
            pc[r] = 0;
            if (ph[r] == 255) begin
              ph[r] = 0;
              ps[r] = (r == 0) ? int'(pre0_in) : int'(pre1_in);
              du[r] = (r == 0) ? int'(duty0_in) : int'(duty1_in);
            end else ph[r]++;
          end else pc[r]++;
        end
      end
    end
  end

  always @(negedge clk) begin
    checks++;
    if (pull_low !== e_pull) begin
      fails++;
      $display("FAIL %s pull_low actual %h expected %h (cycle %0d)", cur_tag, pull_low, e_pull, cyc);
    end
    checks++;
    if ({stat_hi, stat_lo} !== s2) begin
      fails++;
      $display("FAIL R8 status actual %h expected %h (cycle %0d)", {stat_hi, stat_lo}, s2, cyc);
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic count_on(input int bitn, input int len, output int n);
    n = 0;
    repeat (len) begin @(negedge clk); n += int'(pull_low[bitn]); end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int n;
    logic [15:0] held;
    step(5);
    @(negedge clk);
    check("R1 pull_low in reset", int'(pull_low), 0);
    check("R1 status in reset", int'({stat_hi, stat_lo}), 0);
    @(posedge clk); #1; rst_n = 1;
    @(negedge clk);
    check("R1 pull_low after reset", int'(pull_low), 0);

    cur_tag = "R2";
    mode_sel = 32'h4444_4444;
    step(20);
    @(negedge clk);
    check("R7 odd LEDs on with fields 01", int'(pull_low), 16'hAAAA);
    mode_sel = 32'h0000_0001;
    step(2);
    @(negedge clk);
    check("R7 LED0 uses bits 1:0", int'(pull_low), 1);
    mode_sel = 32'h4000_0000;
    step(2);
    @(negedge clk);
    check("R7 LED15 uses bits 31:30", int'(pull_low), 16'h8000);

    cur_tag = "R3";
    mode_sel = 32'hFFFF_AAAA;
    pre0_in = 0; duty0_in = 8'h80; pre1_in = 1; duty1_in = 8'h40;
    step(1100);
    count_on(0, 256, n);
    check("R5 reset duty half on over 256", n, 128);
    count_on(8, 512, n);
    check("R4 rate1 prescale 1 period 512 on 128", n, 128);

    cur_tag = "R6";
    step(100);
    duty0_in = 8'h20;
    step(3);
    count_on(0, 100, n);
    step(600);
    count_on(0, 256, n);
    check("R6 new duty after wrap", n, 32);

    cur_tag = "R5";
    duty0_in = 8'h00;
    step(600);
    count_on(0, 256, n);
    check("R5 duty zero never on", n, 0);

    cur_tag = "R9";
    duty0_in = 8'h80;
    step(600);
    tick_mode = 2;
    step(3);
    @(negedge clk);
    held = pull_low;
    repeat (300) @(negedge clk);
    check("R9 outputs frozen without tick", int'(pull_low), int'(held));
    tick_mode = 0;

    cur_tag = "R4";
    tick_mode = 1;
    step(1100);
    count_on(0, 512, n);
    check("R4 half-rate tick period 512 on 256", n, 256);
    tick_mode = 0;

    cur_tag = "R8";
    rnd_pins = 1;
    step(200);
    rnd_pins = 0;
    pin_in = 16'hA5C3;
    step(3);
    @(negedge clk);
    check("R8 stat_lo pins 7..0", int'(stat_lo), 8'hC3);
    check("R8 stat_hi pins 15..8", int'(stat_hi), 8'hA5);

    step(2);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule